// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder

The block takes a serial stream of information bits and produces a serial stream of code symbols at twice the bit rate. It is meant for the low-rate synchronization channel of a spread-spectrum transmitter. The coder has constraint length 9. Its state is a register holding the eight most recent past bits. Each accepted bit, together with that state, forms a nine-bit window. Two fixed generator masks each select taps from the window, and each code symbol is the XOR of the taps its mask selects.

An upstream source offers a bit with `in_valid_i` and keeps it there until `in_ready_o` is high. Both code symbols for the bit then appear on `sym_o`, one per clock, with `sym_valid_o` high and the first-generator symbol first. The block can take a new bit in the same cycle that the second symbol is shown. A steady source therefore gets a gapless symbol stream at one bit per two clocks.

Top module: `conv_enc_r2`

## Requirements
- R1: While `rst_ni` is low and after it is released, `sym_valid_o` is 0, `in_ready_o` is 1 and all eight past-bit stages hold 0. A first bit of 1 after reset therefore yields symbols 1,1, and a first bit of 0 yields 0,0.
- R2: The first symbol of each bit is the XOR of the window bits selected by mask 753 octal. Window bit 8 (the MSB) is the new bit, and window bit 0 is the bit accepted eight bits earlier.
- R3: The second symbol of each bit is the XOR of the window bits selected by mask 561 octal, with the same window bit order as in R2.
- R4: A bit is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both 1. The first symbol is on `sym_o` with `sym_valid_o`=1 in the next cycle, and the second symbol follows in the cycle after that.
- R5: `in_ready_o` is 0 in the cycle that shows the first symbol, while the second is still pending. A bit offered in that cycle is ignored and leaves the state unchanged.
- R6: While no bit is accepted, the past-bit state does not change, and `sym_valid_o` is 0 once the pending symbols have gone out.
- R7: A bit affects the symbols of the eight bits that follow it, and of no bit after those.
- R8: A bit offered in the cycle that shows the second symbol is accepted. Its first symbol then follows with no idle cycle, so a steady source gets one valid symbol every clock.
- R9: Pulling `rst_ni` low in the middle of a symbol pair drops the pending symbol at once and clears the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An information bit is offered |
| in_bit_i | input | 1 | Information bit |
| in_ready_o | output | 1 | The block can accept a bit in this cycle |
| sym_o | output | 1 | Code symbol |
| sym_valid_o | output | 1 | `sym_o` holds a valid symbol |

## Verification
A wrong past-bit stage or tap shows up as a wrong symbol at `sym_o` no more than eight accepted bits after the bad value enters. The stimulus therefore includes isolated 1 bits followed by at least eight zeros, so every tap position is exposed through the impulse response of both masks. A sequencing fault shows up within two cycles of an accept: as a swapped symbol order, as `in_ready_o` high while the second symbol is still due, or as a bit offered while busy leaking into the state. The bench offers random junk bits in every busy cycle to catch that last case.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int unsigned CONSTR_LEN  = 9;
  localparam int unsigned SYM_PER_BIT = 2;
  typedef logic [CONSTR_LEN-1:0] gen_t;
  // MSB taps the newest bit, LSB the oldest stored bit
  localparam gen_t GEN_C0 = 9'o753;
  localparam gen_t GEN_C1 = 9'o561;
endpackage

// File: rtl/conv_state.sv
module conv_state #(
  parameter int unsigned K = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [K-1:0] window_o
);
  localparam int unsigned MW = K - 1;

  logic [MW-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mem_q <= '0;
    else if (shift_i) mem_q <= window_o[K-1:1];
  end

  assign window_o = {bit_i, mem_q};

  // R6
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(mem_q));
  // R2
  state_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> mem_q[MW-1] == $past(bit_i));
endmodule

// File: rtl/conv_parity.sv
module conv_parity #(
  parameter int unsigned K   = 9,
  parameter logic [K-1:0] GEN = '1
) (
  input  logic [K-1:0] window_i,
  output logic         par_o
);
  assign par_o = ^(window_i & GEN);
endmodule

// File: rtl/sym_serializer.sv
module sym_serializer #(
  parameter int unsigned NUM_SYM = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NUM_SYM-1:0] syms_i,
  output logic               ready_o,
  output logic               sym_o,
  output logic               valid_o
);
  localparam int unsigned CW = $clog2(NUM_SYM + 1);

  logic [NUM_SYM-1:0] buf_q;
  logic [CW-1:0]      rem_q;
  logic               sym_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      rem_q   <= '0;
      sym_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      sym_q   <= syms_i[0];
      buf_q   <= {1'b0, syms_i[NUM_SYM-1:1]};
      rem_q   <= CW'(NUM_SYM - 1);
      valid_q <= 1'b1;
    end else if (rem_q != '0) begin
      sym_q   <= buf_q[0];
      buf_q   <= {1'b0, buf_q[NUM_SYM-1:1]};
      rem_q   <= rem_q - CW'(1);
      valid_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign ready_o = (rem_q == '0);
  assign sym_o   = sym_q;
  assign valid_o = valid_q;

  // R4
  sym_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o && !ready_o);
  // R5
  busy_shows_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> valid_o);
  // R5
  no_load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> ready_o);
  // R4
  second_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !load_i) |=> valid_o && sym_o == $past(buf_q[0]));
endmodule

// File: rtl/conv_enc_r2.sv
module conv_enc_r2
  import conv_enc_pkg::*;
#(
  parameter int unsigned  K  = CONSTR_LEN,
  parameter logic [K-1:0] G0 = GEN_C0,
  parameter logic [K-1:0] G1 = GEN_C1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic in_bit_i,
  output logic in_ready_o,
  output logic sym_o,
  output logic sym_valid_o
);
  localparam int unsigned NS = SYM_PER_BIT;
  localparam logic [NS-1:0][K-1:0] GENS = {G1, G0};

  logic         accept;
  logic [K-1:0] window;
  logic [NS-1:0] syms;

  assign accept = in_valid_i && in_ready_o;

  conv_state #(.K(K)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (accept),
    .bit_i   (in_bit_i),
    .window_o(window)
  );

  for (genvar g = 0; g < NS; g++) begin : g_par
    conv_parity #(.K(K), .GEN(GENS[g])) u_par (
      .window_i(window),
      .par_o   (syms[g])
    );
  end

  sym_serializer #(.NUM_SYM(NS)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .syms_i (syms),
    .ready_o(in_ready_o),
    .sym_o  (sym_o),
    .valid_o(sym_valid_o)
  );

  // R8
  b2b_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && in_ready_o && in_valid_i) |=> sym_valid_o);
  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> !sym_valid_o);
endmodule

// File: tb/sim_conv_enc_r2.sv
module sim_conv_enc_r2;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, sym, sym_valid;
  int   checks = 0, fails = 0;
  logic [7:0] st = '0;
  bit   done = 0;

  always #2 clk = ~clk;

  conv_enc_r2 u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_bit_i(in_bit),
    .in_ready_o(in_ready), .sym_o(sym), .sym_valid_o(sym_valid)
  );

  function automatic logic par(input logic [8:0] w, input logic [8:0] g);
    return ^(w & g);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called at a negedge with in_ready expected high
  task automatic send(input logic b, input logic jv, input logic jb);
    logic [8:0] w;
    logic e0, e1;
    chk(in_ready == 1'b1, "R8 ready before offer", in_ready, 1);
    w  = {b, st};
    e0 = par(w, 9'o753);
    e1 = par(w, 9'o561);
    st = w[8:1];
    in_valid = 1'b1; in_bit = b;
    @(negedge clk);
    chk(sym_valid && sym == e0, "R2 R4 first symbol", {sym_valid, sym}, {1'b1, e0});
    chk(in_ready == 1'b0, "R5 busy on first symbol", in_ready, 0);
    in_valid = jv; in_bit = jb;   // must be ignored
    @(negedge clk);
    chk(sym_valid && sym == e1, "R3 R4 second symbol", {sym_valid, sym}, {1'b1, e1});
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(sym_valid == 1'b0, "R6 idle no symbol", sym_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(sym_valid == 1'b0 && in_ready == 1'b1, "R1 in reset", {sym_valid, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sym_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", {sym_valid, in_ready}, 1);
    // R1: first bit 1 after reset gives 1,1
    send(1'b1, 1'b1, 1'b1);
    // R7: impulse response over the next nine zero bits, junk offered when busy
    for (int i = 0; i < 9; i++) send(1'b0, 1'b1, 1'b1);
    idle(3);
    // R8: back-to-back stream
    for (int i = 0; i < 16; i++) send(1'b1, 1'b0, 1'b0);
    // random mix with gaps and junk
    for (int i = 0; i < 400; i++) begin
      send(1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(3) == 0) idle($urandom_range(1, 3));
    end
    // R9: reset during a pending pair
    in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(sym_valid == 1'b0 && in_ready == 1'b1, "R9 pending dropped", {sym_valid, in_ready}, 1);
    @(negedge clk);
    rst_n = 1'b1;
    st = '0;
    @(negedge clk);
    chk(sym_valid == 1'b0, "R9 no stale symbol", sym_valid, 0);
    // R1 R9: first bit 0 after reset gives 0,0 then state cleared
    send(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) send(1'($urandom), 1'b1, 1'($urandom));
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule